// File: doc/BRIEF.md
# Nested-Priority Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt sources and presents them to a processor on two outputs: a normal interrupt line and a fast interrupt line. Each source is active when its hardware input is high or when software has set its soft-request bit. A per-source enable gates the normal path. A per-source route bit sends the source to the fast path instead, and the enable does not gate that path.

Sixteen programmable vector slots rank chosen sources by priority, and each slot holds a handler address. Slot 0 ranks highest. Any pending normal source that no slot names falls to a non-vectored level, which uses a default handler address. Software acknowledges an interrupt by reading the vector register. That read returns the handler address and raises the controller's current level, so that only higher-ranked sources can assert the normal line. Writing the vector register ends the handler and restores the level that was in force before it. Handlers can therefore nest to any depth within the 17 levels. All registers, including eight identification bytes, sit on a simple single-cycle register bus.

Top module: `nest_vic`

## Requirements
- R1: The raw state of a source is its hardware input OR its soft-request bit. Writing offset 0x018 ORs the data into the soft-request bits and writing 0x01C clears the bits set in the data. The soft bits read back at 0x018 and the raw state reads at 0x008.
- R2: Writing 0x010 ORs the data into the enable bits and writing 0x014 clears the bits set in the data. The enable bits read back at 0x010. The normal status at 0x000 is raw AND enable AND NOT route.
- R3: The route bits are written and read at 0x00C. The fast status at 0x004 is raw AND route, whatever the enable bits hold. The fast output goes high one clock after the fast status becomes nonzero.
- R4: Each vector-control slot k sits at 0x200+4k. Bit 5 enables the slot and bits 4:0 name its source. Slot handler addresses sit at 0x100+4k. Both read back as written, the control through bit 5.
- R5: The level mask of level i holds the sources of the enabled slots below i. Level 16's mask holds all enabled slot sources, and the idle level 17's mask is all ones. One clock after any change, the normal output equals normal status AND the mask of the current level, reduced to one bit.
- R6: A read of 0x030 picks the lowest level i below the current level whose mask i+1 holds a raw source. It then makes i the current level and returns i's handler address. When no such level exists the current level stays and its address is returned. Level 16 and the idle level return the default address, which is held at 0x034.
- R7: A write to 0x030 ignores its data and sets the current level back to the level that was in force when the current level was entered. At the idle level such a write has no effect.
- R8: Nested acknowledges unwind in reverse order: a higher-ranked handler completing returns to the interrupted level, and that level completing returns to idle.
- R9: After reset the handler addresses, slot controls, default address, soft bits, enables and route bits are zero, the level is idle, and both outputs are low.
- R10: A read of an unmapped offset returns zero and a write to one changes nothing. A write to the read-only status at 0x000 is ignored.
- R11: Identification byte k (default bytes 0x90,0x11,0x04,0x00,0x0D,0xF0,0x05,0xB1) reads in bits 7:0 at 0xFE0+4k.
- R12: Bit 0 of a write to 0x020 is stored and reads back at 0x020, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Hardware interrupt request levels |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; needed because the vector read has a side effect |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
The bench nests a low-ranked handler under a higher-ranked one. A design that saved the wrong previous level would unwind straight to idle, or stall at the inner level, and the repeated vector reads would return the wrong handler address. It raises a non-vectored source while a vectored handler runs. A mask built from the wrong slots would let that source break through, or would block it after the unwind. It routes a source to the fast path and then disables it. An enable-gated fast path would drop the fast output there. It also writes the vector register at idle, which a missing idle guard turns into a jump to a stale level that silences the normal output.

// File: rtl/nest_vic_pkg.sv
package nest_vic_pkg;
  // Register word indices (byte offset >> 2)
  localparam logic [9:0] W_STAT_N  = 10'h000;
  localparam logic [9:0] W_STAT_F  = 10'h001;
  localparam logic [9:0] W_RAW     = 10'h002;
  localparam logic [9:0] W_ROUTE   = 10'h003;
  localparam logic [9:0] W_EN_SET  = 10'h004;
  localparam logic [9:0] W_EN_CLR  = 10'h005;
  localparam logic [9:0] W_SW_SET  = 10'h006;
  localparam logic [9:0] W_SW_CLR  = 10'h007;
  localparam logic [9:0] W_GUARD   = 10'h008;
  localparam logic [9:0] W_VECTOR  = 10'h00C;
  localparam logic [9:0] W_DEF_VEC = 10'h00D;
  // Region tags from address bits 11:6
  localparam logic [5:0] RG_HADDR  = 6'h04;
  localparam logic [5:0] RG_SLOT   = 6'h08;
  localparam logic [6:0] RG_IDENT  = 7'h7F;
endpackage

// File: rtl/nest_vic_masks.sv
module nest_vic_masks #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  localparam int SRC_W = $clog2(NSRC)
) (
  input  logic [NSLOT-1:0][SRC_W:0]   slot_ctl,
  output logic [NSLOT+1:0][NSRC-1:0]  lvl_mask
);
  function automatic logic [NSRC-1:0] slot_bit(input logic [SRC_W:0] c);
    slot_bit = c[SRC_W] ? (NSRC'(1) << c[SRC_W-1:0]) : '0;
  endfunction

  assign lvl_mask[0] = '0;
  for (genvar g = 0; g < NSLOT; g++) begin : g_chain
    assign lvl_mask[g+1] = lvl_mask[g] | slot_bit(slot_ctl[g]);
  end
  assign lvl_mask[NSLOT+1] = '1;
endmodule

// File: rtl/nest_vic_level.sv
module nest_vic_level #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  localparam int LVL_W = $clog2(NSLOT + 2),
  localparam logic [LVL_W-1:0] IDLE = LVL_W'(NSLOT + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ack_i,
  input  logic                         done_i,
  input  logic [NSRC-1:0]              raw_i,
  input  logic [NSLOT+1:0][NSRC-1:0]   mask_i,
  output logic [LVL_W-1:0]             cur_o,
  output logic [LVL_W-1:0]             ack_lvl_o
);
  logic [LVL_W-1:0] prev_q [NSLOT+1];
  logic [LVL_W-1:0] prev_cur;

  // Lowest level below cur whose next mask holds a raw source; else cur.
  function automatic logic [LVL_W-1:0] pick(input logic [NSRC-1:0] r,
                                            input logic [NSLOT+1:0][NSRC-1:0] m,
                                            input logic [LVL_W-1:0] cur);
    pick = cur;
    for (int i = NSLOT; i >= 0; i--)
      if (LVL_W'(i) < cur && (r & m[i+1]) != '0) pick = LVL_W'(i);
  endfunction

  assign ack_lvl_o = pick(raw_i, mask_i, cur_o);
  assign prev_cur  = (cur_o == IDLE) ? IDLE : prev_q[cur_o];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_o <= IDLE;
      for (int i = 0; i <= NSLOT; i++) prev_q[i] <= IDLE;
    end else if (done_i) begin
      if (cur_o != IDLE) cur_o <= prev_cur;
    end else if (ack_i && ack_lvl_o < cur_o) begin
      prev_q[ack_lvl_o] <= cur_o;
      cur_o <= ack_lvl_o;
    end
  end

  a_r6_ack_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !done_i && ack_lvl_o < cur_o) |=> cur_o == $past(ack_lvl_o));
  a_r7_done_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && cur_o != IDLE) |=> cur_o == $past(prev_cur));
  a_r7_idle_done_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && cur_o == IDLE) |=> cur_o == IDLE);
  a_r9_level_range: assert property (@(posedge clk) disable iff (!rst_n)
    cur_o <= IDLE);
endmodule

// File: rtl/nest_vic.sv
module nest_vic #(
  parameter int          NSRC     = 32,
  parameter int          NSLOT    = 16,
  parameter int          DW       = 32,
  parameter logic [63:0] ID_BYTES = 64'hB105_F00D_0004_1190,
  localparam int SRC_W = $clog2(NSRC),
  localparam int LVL_W = $clog2(NSLOT + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [11:0]     bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_o,
  output logic            fiq_o
);
  import nest_vic_pkg::*;

  logic [NSRC-1:0] soft_q, en_q, route_q;
  logic            guard_q;
  logic [DW-1:0]   def_q;
  logic [DW-1:0]   haddr_q [NSLOT];
  logic [NSLOT-1:0][SRC_W:0] ctl_q;

  logic [NSRC-1:0] raw, stat_n, stat_f;
  logic [NSLOT+1:0][NSRC-1:0] lvl_mask;
  logic [LVL_W-1:0] cur_lvl, ack_lvl;
  logic [9:0] word;
  logic [3:0] slot;
  logic       in_haddr, in_ctl, in_id, ack, done;
  logic [DW-1:0] vec_rd;

  assign raw    = src_i | soft_q;
  assign stat_n = raw & en_q & ~route_q;
  assign stat_f = raw & route_q;

  assign word     = bus_addr[11:2];
  assign slot     = bus_addr[5:2];
  assign in_haddr = bus_addr[11:6] == RG_HADDR && 32'(slot) < NSLOT;
  assign in_ctl   = bus_addr[11:6] == RG_SLOT  && 32'(slot) < NSLOT;
  assign in_id    = bus_addr[11:5] == RG_IDENT;
  assign done     = bus_wr && word == W_VECTOR;
  assign ack      = bus_rd && !bus_wr && word == W_VECTOR;

  nest_vic_masks #(.NSRC(NSRC), .NSLOT(NSLOT)) u_masks (
    .slot_ctl (ctl_q),
    .lvl_mask (lvl_mask)
  );

  nest_vic_level #(.NSRC(NSRC), .NSLOT(NSLOT)) u_level (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_i     (ack),
    .done_i    (done),
    .raw_i     (raw),
    .mask_i    (lvl_mask),
    .cur_o     (cur_lvl),
    .ack_lvl_o (ack_lvl)
  );

  // Handler address for the level the acknowledge lands on
  assign vec_rd = (32'(ack_lvl) < NSLOT) ? haddr_q[ack_lvl[3:0]] : def_q;

  always_comb begin
    bus_rdata = '0;
    if (in_haddr)   bus_rdata = haddr_q[slot];
    else if (in_ctl) bus_rdata = DW'(ctl_q[slot]);
    else if (in_id)  bus_rdata = DW'(ID_BYTES[{bus_addr[4:2], 3'b000} +: 8]);
    else begin
      case (word)
        W_STAT_N:  bus_rdata = DW'(stat_n);
        W_STAT_F:  bus_rdata = DW'(stat_f);
        W_RAW:     bus_rdata = DW'(raw);
        W_ROUTE:   bus_rdata = DW'(route_q);
        W_EN_SET:  bus_rdata = DW'(en_q);
        W_SW_SET:  bus_rdata = DW'(soft_q);
        W_GUARD:   bus_rdata = DW'(guard_q);
        W_VECTOR:  bus_rdata = vec_rd;
        W_DEF_VEC: bus_rdata = def_q;
        default:   bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_q  <= '0;
      en_q    <= '0;
      route_q <= '0;
      guard_q <= 1'b0;
      def_q   <= '0;
      ctl_q   <= '0;
      for (int i = 0; i < NSLOT; i++) haddr_q[i] <= '0;
    end else if (bus_wr) begin
      if (in_haddr)    haddr_q[slot] <= bus_wdata;
      else if (in_ctl) ctl_q[slot]   <= bus_wdata[SRC_W:0];
      else begin
        case (word)
          W_ROUTE:   route_q <= bus_wdata[NSRC-1:0];
          W_EN_SET:  en_q    <= en_q | bus_wdata[NSRC-1:0];
          W_EN_CLR:  en_q    <= en_q & ~bus_wdata[NSRC-1:0];
          W_SW_SET:  soft_q  <= soft_q | bus_wdata[NSRC-1:0];
          W_SW_CLR:  soft_q  <= soft_q & ~bus_wdata[NSRC-1:0];
          W_GUARD:   guard_q <= bus_wdata[0];
          W_DEF_VEC: def_q   <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= (stat_n & lvl_mask[cur_lvl]) != '0;
      fiq_o <= stat_f != '0;
    end
  end

  // R4: masks only grow with the level number
  for (genvar g = 0; g <= NSLOT; g++) begin : g_chk
    a_r4_mask_nested: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_mask[g] & ~lvl_mask[g+1]) == '0);
  end
  a_r5_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !irq_o);
  a_r3_fiq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_f == '0) |=> !fiq_o);
  a_r3_fiq_ungated: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_f != '0 && en_q == '0) |=> fiq_o);
endmodule

// File: tb/nest_vic_test.sv
`timescale 1ns/1ps
module nest_vic_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  nest_vic uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_HW = 2'd2, OP_OUT = 2'd3;
  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] e;   // read value, or {fiq,irq} for OP_OUT
    logic [7:0]  req;
  } vec_t;
  localparam int NV = 29;
  localparam vec_t TBL [NV] = '{
    '{OP_RD,  12'h008, 32'h0,      32'h0,      8'd9},  // R9 raw clear
    '{OP_WR,  12'h018, 32'h101,    32'h0,      8'd1},
    '{OP_RD,  12'h008, 32'h0,      32'h101,    8'd1},  // R1
    '{OP_HW,  12'h000, 32'h010,    32'h0,      8'd1},
    '{OP_RD,  12'h008, 32'h0,      32'h111,    8'd1},  // R1 hw OR soft
    '{OP_WR,  12'h01C, 32'h001,    32'h0,      8'd1},
    '{OP_RD,  12'h018, 32'h0,      32'h100,    8'd1},  // R1 soft clear
    '{OP_RD,  12'h000, 32'h0,      32'h0,      8'd2},  // R2 none enabled
    '{OP_WR,  12'h010, 32'h110,    32'h0,      8'd2},
    '{OP_WR,  12'h010, 32'h001,    32'h0,      8'd2},
    '{OP_RD,  12'h010, 32'h0,      32'h111,    8'd2},  // R2 enable OR-in
    '{OP_RD,  12'h000, 32'h0,      32'h110,    8'd2},  // R2
    '{OP_OUT, 12'h000, 32'h0,      32'h1,      8'd5},  // R5 idle mask ones
    '{OP_WR,  12'h00C, 32'h100,    32'h0,      8'd3},
    '{OP_RD,  12'h000, 32'h0,      32'h010,    8'd2},  // R2 route removes
    '{OP_RD,  12'h004, 32'h0,      32'h100,    8'd3},  // R3
    '{OP_WR,  12'h014, 32'h100,    32'h0,      8'd2},
    '{OP_RD,  12'h004, 32'h0,      32'h100,    8'd3},  // R3 enable ignored
    '{OP_OUT, 12'h000, 32'h0,      32'h3,      8'd3},  // R3 fast output
    '{OP_WR,  12'h000, 32'hFFFF,   32'h0,      8'd10},
    '{OP_RD,  12'h000, 32'h0,      32'h010,    8'd10}, // R10 status read-only
    '{OP_RD,  12'h040, 32'h0,      32'h0,      8'd10}, // R10 unmapped
    '{OP_RD,  12'hFE0, 32'h0,      32'h90,     8'd11}, // R11
    '{OP_RD,  12'hFFC, 32'h0,      32'hB1,     8'd11}, // R11
    '{OP_WR,  12'h020, 32'h3,      32'h0,      8'd12},
    '{OP_RD,  12'h020, 32'h0,      32'h1,      8'd12}, // R12
    '{OP_WR,  12'h23C, 32'hFF,     32'h0,      8'd4},
    '{OP_RD,  12'h23C, 32'h0,      32'h3F,     8'd4},  // R4
    '{OP_RD,  12'h01C, 32'h0,      32'h0,      8'd10}  // R10 write-only reads 0
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input int req, input logic [11:0] a, input logic [31:0] e);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, e);
  endtask

  task automatic out_chk(input int req, input logic [1:0] e);
    @(negedge clk);
    chk(req, {30'd0, fiq_o, irq_o}, {30'd0, e});
  endtask

  task automatic hw(input logic [31:0] v);
    @(negedge clk);
    src_i = v;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    do_reset();
    // R9 reset state
    out_chk(9, 2'b00);
    rd_chk(9, 12'h200, 32'h0);
    rd_chk(9, 12'h13C, 32'h0);
    rd_chk(9, 12'h034, 32'h0);
    rd_chk(9, 12'h00C, 32'h0);

    for (int k = 0; k < NV; k++) begin
      case (TBL[k].op)
        OP_WR:  wr(TBL[k].a, TBL[k].d);
        OP_RD:  rd_chk(int'(TBL[k].req), TBL[k].a, TBL[k].e);
        OP_HW:  hw(TBL[k].d);
        default: out_chk(int'(TBL[k].req), TBL[k].e[1:0]);
      endcase
    end

    // Nested sequence R8: slot0 -> src5, slot3 -> src9, src12 non-vectored
    do_reset();
    wr(12'h200, 32'h25);
    wr(12'h100, 32'hA000);
    wr(12'h20C, 32'h29);
    wr(12'h10C, 32'hA300);
    wr(12'h034, 32'hD000);
    wr(12'h010, 32'h0000_1220);
    rd_chk(6, 12'h030, 32'hD000);        // R6 nothing pending at idle
    hw(32'h200);
    out_chk(5, 2'b01);                   // R5 src9 at idle
    rd_chk(6, 12'h030, 32'hA300);        // R6 ack slot3
    out_chk(5, 2'b00);                   // R5 level 3 masks src9
    hw(32'h1200);
    out_chk(5, 2'b00);                   // R5 non-vectored blocked
    hw(32'h1220);
    out_chk(8, 2'b01);                   // R8 higher rank breaks through
    rd_chk(8, 12'h030, 32'hA000);        // R8 nested ack slot0
    out_chk(8, 2'b00);
    hw(32'h1200);
    wr(12'h030, 32'hFFFF_FFFF);          // complete inner
    out_chk(8, 2'b00);                   // R8 back at level 3
    rd_chk(8, 12'h030, 32'hA300);        // R8 level 3 still current
    hw(32'h1000);
    wr(12'h030, 32'h0);                  // complete outer
    out_chk(8, 2'b01);                   // R8 idle: src12 visible
    rd_chk(6, 12'h030, 32'hD000);        // R6 non-vectored default
    out_chk(6, 2'b00);                   // R6 level 16 masks src12
    wr(12'h030, 32'h0);
    out_chk(7, 2'b01);                   // R7 restored to idle
    wr(12'h030, 32'h0);                  // R7 write at idle
    out_chk(7, 2'b01);                   // R7 idle write no effect
    wr(12'h200, 32'h05);                 // disable slot0
    hw(32'h20);
    rd_chk(4, 12'h030, 32'hD000);        // R4 disabled slot not vectored
    wr(12'h030, 32'h0);
    summary();
  end
endmodule